// File: doc/BRIEF.md
# Hardware Write-Inhibit Qualifier

This block decides when a memory device may begin an internal write. It watches the raw active-low chip-select, write-enable and output-enable pins. It also takes a digital supply-good flag that an analog comparator produces elsewhere and presents synchronously. From these it issues a single-cycle write-start pulse. The array write logic uses that pulse as its only trigger.

Several guards must all clear before a write can start:

- The supply must be good on the deciding cycle.
- The supply must have stayed good for a programmable number of clock cycles since reset or since it last dropped.
- The synchronised output-enable must be high.
- Chip-select and write-enable must both have been low together for at least a programmable number of sampling cycles. This rejects short glitches on either strobe.

The raw pins cross into the clock domain through a chain of flip-flops before any decision is made.

Top module: `write_qualifier`

## Requirements
- R1: While rstN is low, writeStart is 0; reset also clears the power-up delay count, so no start can occur until the full delay has elapsed after reset, even with supplyGood held high.
- R2: No writeStart pulse is produced while supplyGood is low. A window held entirely during low supply yields no pulse.
- R3: After supplyGood rises, starts stay blocked until it has been high on DELAY_CYCLES consecutive rising edges. Timing for a both-low window already held while the supply was low: supplyGood goes high just before edge 1, and the pulse appears after edge DELAY_CYCLES+1 and not before.
- R4: A drop of supplyGood for even one cycle restarts the delay. A window shortly after recovery yields no pulse.
- R5: A window with csN and weN both low (active low, logic 0 = asserted) for fewer than FILTER_CYCLES consecutive sampling edges yields no pulse. A low on only one of the two strobes never yields a pulse.
- R6: A window of at least FILTER_CYCLES edges, with all other guards clear, yields exactly one pulse, one cycle wide. Counting the first edge that samples both raw strobes low as edge 1, writeStart is high after edge SYNC_STAGES+FILTER_CYCLES and low after the edge before it.
- R7: While the synchronised oeN is low, no pulse is produced, whatever the state of csN and weN.
- R8: If a guard clears while a qualified window is still held, one pulse is issued late for that window, and no more.
- R9: Each separate window produces its own pulse, so two qualified windows separated by a short release give two pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low reset |
| supplyGood | input | 1 | Synchronous supply-above-threshold flag |
| csN | input | 1 | Raw chip select, active low |
| weN | input | 1 | Raw write enable, active low |
| oeN | input | 1 | Raw output enable, active low |
| writeStart | output | 1 | One-cycle qualified write-start pulse |

## Verification
The bench builds the block with DELAY_CYCLES=40, FILTER_CYCLES=3 and SYNC_STAGES=2. The short lockout lets the power-up delay edge, the one-cycle supply drop and the post-reset lockout all be checked within a few hundred cycles. A filter width of 3 puts the below-width case (2 edges) right next to the exact-width case (3 edges), and the two-stage chain fixes the start latency at 5 edges, which the bench checks cycle-exactly.

// File: rtl/wrq_pkg.sv
package wrq_pkg;
  // Strobes passed from the power-state control to the pin datapath
  typedef struct packed {
    logic writeAllow;   // supply good and lockout expired this cycle
  } wrqStrobes_t;
endpackage

// File: rtl/wrq_ctrl.sv
module wrq_ctrl
  import wrq_pkg::*;
#(
  parameter int DELAY_CYCLES = 1000000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        supplyGood,
  output wrqStrobes_t strobes
);
  localparam int CW = (DELAY_CYCLES < 1) ? 1 : $clog2(DELAY_CYCLES + 1);
  localparam logic [CW-1:0] DELAY_END = CW'(DELAY_CYCLES);

  logic [CW-1:0] delayCnt;
  logic          delayDone;

  // Lockout timer: counts good-supply edges, restarts on any drop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      delayCnt <= '0;
    end else if (!supplyGood) begin
      delayCnt <= '0;
    end else if (delayCnt != DELAY_END) begin
      delayCnt <= delayCnt + 1'b1;
    end
  end

  assign delayDone          = (delayCnt == DELAY_END);
  assign strobes.writeAllow = supplyGood & delayDone;
endmodule

// File: rtl/wrq_datapath.sv
module wrq_datapath
  import wrq_pkg::*;
#(
  parameter int FILTER_CYCLES = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        weN,
  input  logic        oeN,
  input  wrqStrobes_t strobes,
  output logic        writeStart
);
  localparam int NPIN = 3;
  localparam int PIN_CS = 0;
  localparam int PIN_WE = 1;
  localparam int PIN_OE = 2;
  localparam int FW = (FILTER_CYCLES < 2) ? 1 : $clog2(FILTER_CYCLES + 1);
  localparam logic [FW-1:0] RUN_LAST = FW'(FILTER_CYCLES - 1);

  logic [NPIN-1:0]        rawPins;
  logic [NPIN-1:0]        syncPins;
  logic [SYNC_STAGES-1:0] chain [NPIN];

  assign rawPins = {oeN, weN, csN};

  // Per-pin synchroniser chain, idle (high) out of reset
  for (genvar p = 0; p < NPIN; p++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain[p] <= '1;
      end else begin
        chain[p] <= {chain[p][SYNC_STAGES-2:0], rawPins[p]};
      end
    end
    assign syncPins[p] = chain[p][SYNC_STAGES-1];
  end

  logic          bothLow;
  logic          oeInhibit;
  logic [FW-1:0] lowRun;
  logic          widthMet;
  logic          fired;
  logic          startNow;

  assign bothLow   = ~syncPins[PIN_CS] & ~syncPins[PIN_WE];
  assign oeInhibit = ~syncPins[PIN_OE];

  // Glitch filter: length of the current both-low window, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun <= '0;
    end else if (!bothLow) begin
      lowRun <= '0;
    end else if (lowRun != RUN_LAST) begin
      lowRun <= lowRun + 1'b1;
    end
  end

  assign widthMet = bothLow & (lowRun == RUN_LAST);
  assign startNow = widthMet & ~fired & ~oeInhibit & strobes.writeAllow;

  // One start per window: flag set on start, cleared when window ends
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fired <= 1'b0;
    end else if (!bothLow) begin
      fired <= 1'b0;
    end else if (startNow) begin
      fired <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      writeStart <= 1'b0;
    end else begin
      writeStart <= startNow;
    end
  end
endmodule

// File: rtl/write_qualifier.sv
module write_qualifier
  import wrq_pkg::*;
#(
  parameter int DELAY_CYCLES  = 1000000,
  parameter int FILTER_CYCLES = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyGood,
  input  logic csN,
  input  logic weN,
  input  logic oeN,
  output logic writeStart
);
  wrqStrobes_t strobes;

  wrq_ctrl #(
    .DELAY_CYCLES(DELAY_CYCLES)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .supplyGood (supplyGood),
    .strobes    (strobes)
  );

  wrq_datapath #(
    .FILTER_CYCLES(FILTER_CYCLES),
    .SYNC_STAGES  (SYNC_STAGES)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .csN        (csN),
    .weN        (weN),
    .oeN        (oeN),
    .strobes    (strobes),
    .writeStart (writeStart)
  );
endmodule

// File: rtl/write_qualifier_chk.sv
module write_qualifier_chk #(
  parameter int DELAY_CYCLES = 1000000
) (
  input logic clk,
  input logic rstN,
  input logic supplyGood,
  input logic writeStart
);
  localparam int RW = $clog2(DELAY_CYCLES + 2);
  localparam logic [RW-1:0] RUN_CAP = RW'(DELAY_CYCLES);

  // Independent tally of consecutive good-supply edges
  logic [RW-1:0] goodRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      goodRun <= '0;
    end else if (!supplyGood) begin
      goodRun <= '0;
    end else if (goodRun != RUN_CAP) begin
      goodRun <= goodRun + 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rstN |=> !writeStart); // R1
  AST_NO_START_LOW_SUPPLY: assert property (@(posedge clk) disable iff (!rstN)
    !supplyGood |=> !writeStart); // R2
  AST_LOCKOUT_HONOURED: assert property (@(posedge clk) disable iff (!rstN)
    writeStart |-> ($past(goodRun) >= RUN_CAP)); // R3
  AST_SINGLE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    writeStart |=> !writeStart); // R6
endmodule

bind write_qualifier write_qualifier_chk #(
  .DELAY_CYCLES(DELAY_CYCLES)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .supplyGood (supplyGood),
  .writeStart (writeStart)
);

// File: tb/sim_write_qualifier.sv
`timescale 1ns/1ps
module sim_write_qualifier;
  localparam int DLY  = 40;
  localparam int FILT = 3;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyGood = 1'b1;
  logic csN = 1'b1;
  logic weN = 1'b1;
  logic oeN = 1'b1;
  logic writeStart;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  write_qualifier #(
    .DELAY_CYCLES (DLY),
    .FILTER_CYCLES(FILT),
    .SYNC_STAGES  (SYNC)
  ) u0 (
    .clk        (clk),
    .rstN       (rstN),
    .supplyGood (supplyGood),
    .csN        (csN),
    .weN        (weN),
    .oeN        (oeN),
    .writeStart (writeStart)
  );

  always @(negedge clk) if (writeStart) pulses++;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Hold both strobes low for len sampling edges, then idle for tail
  task automatic runWindow(input int len, input int tail, output int got);
    int base;
    @(posedge clk); base = pulses;
    @(negedge clk); csN = 1'b0; weN = 1'b0;
    repeat (len) @(negedge clk);
    csN = 1'b1; weN = 1'b1;
    repeat (tail) @(negedge clk);
    @(posedge clk); got = pulses - base;
  endtask

  task automatic testReset();
    int base;
    base = pulses;
    @(negedge clk); csN = 1'b0; weN = 1'b0;
    repeat (10) @(negedge clk);
    check("R1 writeStart during reset", int'(writeStart), 0);
    csN = 1'b1; weN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 no pulse in reset", pulses - base, 0);
    rstN = 1'b1;
  endtask

  task automatic testLockoutAfterReset();
    int got;
    runWindow(10, 10, got);
    check("R1 lockout after reset", got, 0);
    repeat (30) @(negedge clk);
  endtask

  task automatic testLatency();
    @(negedge clk); csN = 1'b0; weN = 1'b0;
    repeat (SYNC + FILT - 1) @(posedge clk);
    @(negedge clk);
    check("R6 before start edge", int'(writeStart), 0);
    @(posedge clk); @(negedge clk);
    check("R6 at start edge", int'(writeStart), 1);
    @(posedge clk); @(negedge clk);
    check("R6 one cycle wide", int'(writeStart), 0);
    repeat (10) @(negedge clk);
    check("R6 no repeat while held", int'(writeStart), 0);
    csN = 1'b1; weN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic testFilter();
    int got;
    int base;
    runWindow(FILT - 1, 10, got);
    check("R5 short window rejected", got, 0);
    runWindow(FILT, 10, got);
    check("R6 exact width accepted", got, 1);
    runWindow(12, 10, got);
    check("R6 long window single pulse", got, 1);
    @(posedge clk); base = pulses;
    @(negedge clk); csN = 1'b0;
    repeat (12) @(negedge clk);
    csN = 1'b1; weN = 1'b0;
    repeat (12) @(negedge clk);
    weN = 1'b1;
    repeat (8) @(negedge clk);
    @(posedge clk);
    check("R5 single strobe low", pulses - base, 0);
  endtask

  task automatic testOutputEnable();
    int got;
    oeN = 1'b0;
    runWindow(12, 10, got);
    check("R7 oe low blocks", got, 0);
    @(posedge clk); got = pulses;
    @(negedge clk); csN = 1'b0; weN = 1'b0;
    repeat (8) @(negedge clk);
    oeN = 1'b1;
    repeat (10) @(negedge clk);
    csN = 1'b1; weN = 1'b1;
    repeat (10) @(negedge clk);
    @(posedge clk);
    check("R8 late start after oe release", pulses - got, 1);
  endtask

  task automatic testBackToBack();
    int base;
    @(posedge clk); base = pulses;
    @(negedge clk); csN = 1'b0; weN = 1'b0;
    repeat (6) @(negedge clk);
    csN = 1'b1; weN = 1'b1;
    repeat (3) @(negedge clk);
    csN = 1'b0; weN = 1'b0;
    repeat (6) @(negedge clk);
    csN = 1'b1; weN = 1'b1;
    repeat (10) @(negedge clk);
    @(posedge clk);
    check("R9 two windows two pulses", pulses - base, 2);
  endtask

  task automatic testSupply();
    int got;
    @(negedge clk); supplyGood = 1'b0;
    runWindow(12, 10, got);
    check("R2 low supply blocks", got, 0);
    // Window already held while supply low, then supply rises
    @(negedge clk); csN = 1'b0; weN = 1'b0;
    repeat (6) @(negedge clk);
    supplyGood = 1'b1;
    repeat (DLY) @(posedge clk);
    @(negedge clk);
    check("R3 still locked at delay end", int'(writeStart), 0);
    @(posedge clk); @(negedge clk);
    check("R3 start right after delay", int'(writeStart), 1);
    csN = 1'b1; weN = 1'b1;
    repeat (6) @(negedge clk);
    runWindow(8, 10, got);
    check("R3 open after delay", got, 1);
    // One-cycle drop restarts the delay
    @(negedge clk); supplyGood = 1'b0;
    @(negedge clk); supplyGood = 1'b1;
    repeat (5) @(negedge clk);
    runWindow(10, 10, got);
    check("R4 drop restarts lockout", got, 0);
    repeat (30) @(negedge clk);
    runWindow(10, 10, got);
    check("R4 open after full delay again", got, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testLockoutAfterReset();
    testLatency();
    testFilter();
    testOutputEnable();
    testBackToBack();
    testSupply();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule